// File: doc/BRIEF.md
# Page Access Rights Checker

This block takes one translation entry that has already been found for a virtual address. From that entry, the current privilege level and the kind of access being attempted, it works out the physical address, the read/write/execute rights the access may use, and the first fault the access raises. It is purely combinational: entry storage, the lookup, and delivery of the fault to the processor are handled by other blocks.

The rights come from three sources, applied in order. First, the privilege window and the page type set the base rights. Next, access-id matching against a bank of protection-id registers can remove write rights. Last, the dirty, break and reference bits of the entry each trim the rights further and can each raise a fault. When physical mode is selected, none of these checks are made.

Top module: `pa_rights_check`

## Requirements
- R1: When `phys_mode` is 1, `paddr` equals `vaddr`, `perm_mask` is 3'b111, and no fault is raised, whatever the other inputs are.
- R2: `perm_mask` bit 0 is read, bit 1 is write and bit 2 is execute. The privilege window allows read when `priv` <= `ent_pl1`, allows write when `priv` <= `ent_pl2`, and allows execute when `ent_pl2` <= `priv` <= `ent_pl1`.
- R3: `ent_type` sets which window rights can appear in the mask: 0 allows read only, 1 allows read and write, 2 allows read and execute, 3 allows all three, and 4 to 7 allow execute only.
- R4: A protection-id hit needs three things: `prot_en` is 1, `ent_aid` is nonzero, and at least one of the `NUM_PID` protection-id registers equals `ent_aid`*2+1. Register i sits at bits [i*(AID_W+1) +: AID_W+1] of `pid_regs`. A hit clears the write bit of the mask. A write access that hits raises fault code 1 at once. Without a hit, the registers have no effect.
- R5: `acc_kind` is encoded as 0 none, 1 read, 2 write, 3 execute. An access of kind none never faults, and it returns the mask after the protection-id step.
- R6: If the access kind's bit is missing from the mask, the fault is code 2 for execute and code 3 for read or write. The mask is then returned without the dirty, break or reference trimming.
- R7: Once the access passes the rights test: a clear D bit removes write from the mask, and a write raises code 4. A set B bit removes write from the mask, and a write raises code 5. A break fault overrides a dirty fault.
- R8: Once the access passes the rights test, a set T bit reduces the mask to execute only. Any access other than execute then raises code 6, which overrides both the dirty and the break faults.
- R9: Outside physical mode, `paddr` is `ent_ppn` placed above the low `PAGE_BITS` bits of `vaddr`.
- R10: `fault_valid` is 1 exactly when `fault_code` is nonzero. Code 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phys_mode | input | 1 | Translation bypassed |
| prot_en | input | 1 | Enables access-id checking |
| priv | input | 2 | Current privilege level, 0 most privileged |
| acc_kind | input | 2 | 0 none, 1 read, 2 write, 3 execute |
| vaddr | input | ADDR_W | Virtual address |
| ent_ppn | input | ADDR_W-PAGE_BITS | Entry physical page number |
| ent_aid | input | AID_W | Entry access id, 0 means public |
| ent_pl1 | input | 2 | Read / upper execute privilege bound |
| ent_pl2 | input | 2 | Write / lower execute privilege bound |
| ent_type | input | 3 | Page type |
| ent_b | input | 1 | Break on write |
| ent_d | input | 1 | Page dirty |
| ent_t | input | 1 | Reference trap |
| pid_regs | input | NUM_PID*(AID_W+1) | Protection-id registers, packed |
| paddr | output | ADDR_W | Physical address |
| perm_mask | output | 3 | Granted rights {x,w,r} |
| fault_valid | output | 1 | A fault is raised |
| fault_code | output | 4 | Fault code |

## Verification
The embedded assertions check several invariants on every input change. Physical mode always gives full rights and a pass-through address. A protection-id hit never leaves write rights in the mask. An access of kind none is never faulted. An instruction-protection fault only comes from an execute access. A reference fault always leaves execute as the only right. Only the bench scenarios can show the rest, because each of these depends on a specific combination of inputs: the exact fault codes, the priority of T over B over D, the privilege-window boundaries at equal levels, and the cases where a disabled check or a zero access id leaves the result unchanged.

// File: rtl/pa_rights_pkg.sv
package pa_rights_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_kind_e;

  typedef enum logic [3:0] {
    FLT_NONE   = 4'd0,
    FLT_PID    = 4'd1,
    FLT_IPROT  = 4'd2,
    FLT_RIGHTS = 4'd3,
    FLT_DIRTY  = 4'd4,
    FLT_BREAK  = 4'd5,
    FLT_REF    = 4'd6
  } fault_e;

  localparam int MB_R = 0;
  localparam int MB_W = 1;
  localparam int MB_X = 2;

  // Rights granted by the privilege window alone, packed {x,w,r}.
  function automatic logic [2:0] window_rights(input logic [1:0] lvl,
                                               input logic [1:0] hi_bound,
                                               input logic [1:0] lo_bound);
    logic [2:0] w;
    w[MB_R] = (lvl <= hi_bound);
    w[MB_W] = (lvl <= lo_bound);
    w[MB_X] = (lo_bound <= lvl) && (lvl <= hi_bound);
    return w;
  endfunction

  // Rights a page type is able to grant, packed {x,w,r}.
  function automatic logic [2:0] type_allow(input logic [2:0] ptype);
    logic [2:0] a;
    case (ptype)
      3'd0:    a = 3'b001;
      3'd1:    a = 3'b011;
      3'd2:    a = 3'b101;
      3'd3:    a = 3'b111;
      default: a = 3'b100;
    endcase
    return a;
  endfunction

  // Mask bit requested by an access kind (zero for none).
  function automatic logic [2:0] kind_bit(input acc_kind_e k);
    logic [2:0] b;
    case (k)
      ACC_READ:  b = 3'b001;
      ACC_WRITE: b = 3'b010;
      ACC_EXEC:  b = 3'b100;
      default:   b = 3'b000;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pa_rights_decode.sv
module pa_rights_decode
  import pa_rights_pkg::*;
(
  input  logic [1:0] priv,
  input  logic [1:0] pl1,
  input  logic [1:0] pl2,
  input  logic [2:0] ptype,
  output logic [2:0] base_mask
);
  logic [2:0] win;

  always_comb begin
    win       = window_rights(priv, pl1, pl2);
    base_mask = win & type_allow(ptype);
  end
endmodule

// File: rtl/pa_pid_matcher.sv
module pa_pid_matcher #(
  parameter int AID_W   = 18,
  parameter int NUM_PID = 4
) (
  input  logic                           prot_en,
  input  logic [AID_W-1:0]               aid,
  input  logic [NUM_PID*(AID_W+1)-1:0]   pid_regs,
  output logic                           hit
);
  localparam int PID_W = AID_W + 1;

  logic [PID_W-1:0]   key;
  logic [NUM_PID-1:0] eq;

  assign key = {aid, 1'b1};

  for (genvar i = 0; i < NUM_PID; i++) begin : g_cmp
    assign eq[i] = (pid_regs[i*PID_W +: PID_W] == key);
  end

  assign hit = prot_en && (aid != '0) && (|eq);
endmodule

// File: rtl/pa_fault_resolve.sv
module pa_fault_resolve
  import pa_rights_pkg::*;
(
  input  acc_kind_e  kind,
  input  logic [2:0] mask_in,
  input  logic       pid_hit,
  input  logic       bit_d,
  input  logic       bit_b,
  input  logic       bit_t,
  output logic [2:0] mask_out,
  output fault_e     code
);
  always_comb begin
    mask_out = mask_in;
    code     = FLT_NONE;
    if (pid_hit && kind == ACC_WRITE) begin
      code = FLT_PID;
    end else if (kind == ACC_NONE) begin
      code = FLT_NONE;
    end else if ((mask_in & kind_bit(kind)) == 3'b000) begin
      code = (kind == ACC_EXEC) ? FLT_IPROT : FLT_RIGHTS;
    end else begin
      // lowest priority first; later stages overwrite the code
      if (!bit_d) begin
        if (kind == ACC_WRITE) code = FLT_DIRTY;
        mask_out[MB_W] = 1'b0;
      end
      if (bit_b) begin
        if (kind == ACC_WRITE) code = FLT_BREAK;
        mask_out[MB_W] = 1'b0;
      end
      if (bit_t) begin
        if (kind != ACC_EXEC) code = FLT_REF;
        mask_out = mask_out & 3'b100;
      end
    end
  end

  always_comb begin
    if (code == FLT_IPROT)
      a_r6_iprot_exec_only : assert (kind == ACC_EXEC)
        else $error("instruction-protection fault on a non-execute access");
    if (code == FLT_REF)
      a_r8_ref_exec_mask : assert (mask_out[1:0] == 2'b00)
        else $error("reference fault left read or write rights");
  end
endmodule

// File: rtl/pa_rights_check.sv
module pa_rights_check
  import pa_rights_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int AID_W     = 18,
  parameter int NUM_PID   = 4
) (
  input  logic                           phys_mode,
  input  logic                           prot_en,
  input  logic [1:0]                     priv,
  input  logic [1:0]                     acc_kind,
  input  logic [ADDR_W-1:0]              vaddr,
  input  logic [ADDR_W-PAGE_BITS-1:0]    ent_ppn,
  input  logic [AID_W-1:0]               ent_aid,
  input  logic [1:0]                     ent_pl1,
  input  logic [1:0]                     ent_pl2,
  input  logic [2:0]                     ent_type,
  input  logic                           ent_b,
  input  logic                           ent_d,
  input  logic                           ent_t,
  input  logic [NUM_PID*(AID_W+1)-1:0]   pid_regs,
  output logic [ADDR_W-1:0]              paddr,
  output logic [2:0]                     perm_mask,
  output logic                           fault_valid,
  output logic [3:0]                     fault_code
);
  localparam int PPN_W = ADDR_W - PAGE_BITS;

  // named internal events
  logic [2:0]  base_mask;
  logic        pid_hit;
  logic [2:0]  pid_mask;
  logic [2:0]  final_mask;
  fault_e      xlat_code;
  acc_kind_e   kind;
  logic [ADDR_W-1:0] xlat_addr;

  assign kind = acc_kind_e'(acc_kind);

  pa_rights_decode u_decode (
    .priv      (priv),
    .pl1       (ent_pl1),
    .pl2       (ent_pl2),
    .ptype     (ent_type),
    .base_mask (base_mask)
  );

  pa_pid_matcher #(.AID_W(AID_W), .NUM_PID(NUM_PID)) u_pid (
    .prot_en  (prot_en),
    .aid      (ent_aid),
    .pid_regs (pid_regs),
    .hit      (pid_hit)
  );

  assign pid_mask = pid_hit ? (base_mask & 3'b101) : base_mask;

  pa_fault_resolve u_resolve (
    .kind     (kind),
    .mask_in  (pid_mask),
    .pid_hit  (pid_hit),
    .bit_d    (ent_d),
    .bit_b    (ent_b),
    .bit_t    (ent_t),
    .mask_out (final_mask),
    .code     (xlat_code)
  );

  assign xlat_addr = {ent_ppn[PPN_W-1:0], vaddr[PAGE_BITS-1:0]};

  always_comb begin
    if (phys_mode) begin
      paddr      = vaddr;
      perm_mask  = 3'b111;
      fault_code = FLT_NONE;
    end else begin
      paddr      = xlat_addr;
      perm_mask  = final_mask;
      fault_code = xlat_code;
    end
    fault_valid = (fault_code != FLT_NONE);
  end

  always_comb begin
    if (phys_mode)
      a_r1_phys_full : assert (perm_mask == 3'b111 && !fault_valid && paddr == vaddr)
        else $error("physical mode did not pass through");
    if (!phys_mode && pid_hit)
      a_r4_pid_no_write : assert (!perm_mask[MB_W])
        else $error("protection-id hit left write rights");
    if (kind == ACC_NONE)
      a_r5_none_quiet : assert (!fault_valid)
        else $error("access of kind none raised a fault");
  end
endmodule

// File: tb/pa_rights_check_tb.sv
module pa_rights_check_tb;
  localparam int ADDR_W = 32, PAGE_BITS = 12, AID_W = 18, NUM_PID = 4;
  localparam int PID_W = AID_W + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic phys_mode, prot_en, ent_b, ent_d, ent_t, fault_valid;
  logic [1:0] priv, acc_kind, ent_pl1, ent_pl2;
  logic [2:0] ent_type, perm_mask;
  logic [3:0] fault_code;
  logic [ADDR_W-1:0] vaddr, paddr;
  logic [ADDR_W-PAGE_BITS-1:0] ent_ppn;
  logic [AID_W-1:0] ent_aid;
  logic [PID_W-1:0] pid_r [NUM_PID];
  logic [NUM_PID*PID_W-1:0] pid_regs;

  always_comb
    for (int i = 0; i < NUM_PID; i++) pid_regs[i*PID_W +: PID_W] = pid_r[i];

  pa_rights_check u_dut (
    .phys_mode(phys_mode), .prot_en(prot_en), .priv(priv), .acc_kind(acc_kind),
    .vaddr(vaddr), .ent_ppn(ent_ppn), .ent_aid(ent_aid), .ent_pl1(ent_pl1),
    .ent_pl2(ent_pl2), .ent_type(ent_type), .ent_b(ent_b), .ent_d(ent_d),
    .ent_t(ent_t), .pid_regs(pid_regs), .paddr(paddr), .perm_mask(perm_mask),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic model(output logic [31:0] pa, output logic [2:0] m, output logic [3:0] c);
    int p, need;
    bit rd, wr, ex, hit;
    p  = int'(priv);
    rd = p <= int'(ent_pl1);
    wr = p <= int'(ent_pl2);
    ex = (int'(ent_pl2) <= p) && (p <= int'(ent_pl1));
    case (ent_type)
      0: m = {1'b0, 1'b0, rd};
      1: m = {1'b0, wr, rd};
      2: m = {ex, 1'b0, rd};
      3: m = {ex, wr, rd};
      default: m = {ex, 2'b00};
    endcase
    c = 0;
    if (phys_mode) begin pa = vaddr; m = 3'b111; return; end
    pa = (32'(ent_ppn) << PAGE_BITS) | (vaddr & 32'hfff);
    hit = 0;
    if (prot_en && ent_aid != 0)
      for (int i = 0; i < NUM_PID; i++)
        if (32'(pid_r[i]) == 32'(ent_aid) * 2 + 1) hit = 1;
    if (hit) begin
      m[1] = 0;
      if (acc_kind == 2) begin c = 1; return; end
    end
    if (acc_kind == 0) return;
    need = (acc_kind == 1) ? 1 : (acc_kind == 2) ? 2 : 4;
    if ((int'(m) & need) == 0) begin c = (acc_kind == 3) ? 2 : 3; return; end
    if (!ent_d) begin if (acc_kind == 2) c = 4; m[1] = 0; end
    if (ent_b)  begin if (acc_kind == 2) c = 5; m[1] = 0; end
    if (ent_t)  begin if (acc_kind != 3) c = 6; m = m & 3'b100; end
  endtask

  task automatic check(input string tag);
    logic [31:0] epa; logic [2:0] em; logic [3:0] ec;
    model(epa, em, ec);
    n_checks++;
    if (paddr !== epa || perm_mask !== em || fault_code !== ec || fault_valid !== (ec != 0)) begin
      n_fail++;
      $display("FAIL %s: pa=%h mask=%b code=%0d valid=%b expected pa=%h mask=%b code=%0d valid=%b",
               tag, paddr, perm_mask, fault_code, fault_valid, epa, em, ec, ec != 0);
    end
  endtask

  task automatic base_entry();
    phys_mode = 0; prot_en = 0; priv = 0; acc_kind = 1; vaddr = 32'h1234_5678;
    ent_ppn = 20'hABCDE; ent_aid = 0; ent_pl1 = 3; ent_pl2 = 3; ent_type = 3;
    ent_b = 0; ent_d = 1; ent_t = 0;
    for (int i = 0; i < NUM_PID; i++) pid_r[i] = '0;
  endtask

  task automatic apply(input string tag);
    @(posedge clk); @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    base_entry();
    @(negedge clk);
    check("R9 R2 initial read");
    phys_mode = 1; acc_kind = 2; ent_t = 1; ent_type = 0; apply("R1 physical bypass");
    base_entry(); acc_kind = 0; ent_t = 1; ent_d = 0; apply("R5 none kind");
    base_entry(); priv = 2; ent_pl1 = 2; ent_pl2 = 2; acc_kind = 3; apply("R2 exec at equal bounds");
    base_entry(); priv = 3; ent_pl1 = 2; acc_kind = 1; apply("R6 read above pl1");
    base_entry(); priv = 1; ent_pl1 = 3; ent_pl2 = 2; acc_kind = 3; apply("R2 exec below pl2 window");
    base_entry(); ent_type = 5; acc_kind = 1; apply("R3 exec-only type read");
    base_entry(); ent_type = 2; acc_kind = 2; apply("R3 read/exec type write");
    base_entry(); prot_en = 1; ent_aid = 18'h155; pid_r[2] = {18'h155, 1'b1}; acc_kind = 2;
      apply("R4 pid write fault");
    acc_kind = 1; apply("R4 pid read keeps read");
    pid_r[2] = {18'h155, 1'b0}; acc_kind = 2; apply("R4 low bit clear no hit");
    pid_r[2] = {18'h155, 1'b1}; prot_en = 0; apply("R4 protection disabled");
    base_entry(); prot_en = 1; pid_r[0] = 19'h1; acc_kind = 2; apply("R4 public id zero");
    base_entry(); ent_d = 0; acc_kind = 2; apply("R7 dirty fault");
    base_entry(); ent_d = 0; ent_b = 1; acc_kind = 2; apply("R7 break over dirty");
    base_entry(); ent_d = 0; ent_b = 1; ent_t = 1; acc_kind = 2; apply("R8 ref over break");
    base_entry(); ent_t = 1; acc_kind = 3; apply("R8 exec with T no fault");
    base_entry(); ent_t = 1; acc_kind = 1; apply("R8 read with T");
    base_entry(); ent_b = 1; acc_kind = 1; apply("R7 break read trims write");
    base_entry(); ent_type = 3; priv = 3; ent_pl1 = 0; ent_pl2 = 0; acc_kind = 3;
      apply("R6 exec protection code");

    for (int n = 0; n < 4000; n++) begin
      phys_mode = ($urandom % 8) == 0;
      prot_en   = $urandom % 2;
      priv      = 2'($urandom); acc_kind = 2'($urandom);
      vaddr     = $urandom; ent_ppn = 20'($urandom);
      ent_aid   = (($urandom % 4) == 0) ? '0 : 18'($urandom);
      ent_pl1   = 2'($urandom); ent_pl2 = 2'($urandom); ent_type = 3'($urandom);
      ent_b     = $urandom % 2; ent_d = $urandom % 2; ent_t = $urandom % 2;
      for (int i = 0; i < NUM_PID; i++) pid_r[i] = 19'($urandom);
      if ($urandom % 2) pid_r[$urandom % NUM_PID] = {ent_aid, 1'b1};
      apply("random R2 R3 R4 R6 R7 R8 R9 R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule